// File: doc/BRIEF.md
# Scatter-gather descriptor table generator

This block turns one contiguous buffer (a base address and a byte count) into a chain of 64-bit scatter-gather transfer descriptors for a host-controller DMA engine. A single `start` pulse launches generation. The block first screens the request for errors. If the request is accepted, it emits one descriptor per accepted handshake on a valid/ready stream. Each accepted descriptor is also stored in a small descriptor table at its chain index, and a combinational read port gives access to the table.

Long buffers are cut into pieces of at most `CHUNK_MAX` bytes (65,528 by default). Only the piece that finishes the buffer carries the end-of-chain flag. At the end the block pulses `done` and holds the number of descriptors produced. A rejected request produces no descriptors and reports an error code instead.

Top module: `adt_gen`

## Requirements
- R1: Descriptor layout on `dsc_data` and in the table: attribute in bits [15:0], piece length in bits [31:16], 32-bit piece address in bits [63:32].
- R2: Every emitted descriptor has attribute bit 0 (valid) set, bits [5:4] = 2'b10 (transfer data) and bit 2 (interrupt) clear, so the attribute is 16'h0021 or, with bit 1 (end) set, 16'h0023.
- R3: Each piece length is the smaller of the bytes still uncovered and `CHUNK_MAX`, and each piece address is the base plus the bytes covered by the earlier pieces.
- R4: Bit 1 (end) is set only on the descriptor whose piece covers all remaining bytes, and after it `desc_count` equals the number of descriptors emitted.
- R5: A zero total length is rejected with `err_code` = 1 (misaligned): `done` pulses on the cycle after `start`, no descriptor is emitted and `desc_count` is 0.
- R6: A base address with any bit above bit 31 set is rejected with `err_code` = 2 (bad address). When the length is also zero, code 1 wins.
- R7: A request needing more than `DEPTH` (16) descriptors is rejected with code 1 before any descriptor is emitted. Exactly `DEPTH` full pieces is accepted.
- R8: While `dsc_valid` is high and `dsc_ready` is low, `dsc_valid` stays high and `dsc_data` and `dsc_index` stay stable. The chain advances only on an accepted handshake.
- R9: Each accepted descriptor is written to table entry `dsc_index` and can be read on `rd_data` via `rd_idx`. Entries beyond the count of the current chain keep their earlier contents.
- R10: `busy` is high from the cycle after an accepted `start` until the last descriptor is accepted. `dsc_valid` is low while not busy, and a `start` during `busy` is ignored.
- R11: `done` is a one-cycle pulse. `err_code` (0 = success) and `desc_count` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch generation (ignored while busy) |
| base_addr | input | BASE_W (64) | Buffer base address |
| total_len | input | LEN_W (32) | Buffer length in bytes |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 misaligned/overflow, 2 bad address |
| desc_count | output | CNT_W (5) | Number of descriptors produced |
| dsc_valid | output | 1 | Descriptor on `dsc_data` is valid |
| dsc_ready | input | 1 | Consumer accepts the descriptor |
| dsc_data | output | 64 | Current descriptor |
| dsc_index | output | IDX_W (4) | Chain index of current descriptor |
| rd_idx | input | IDX_W (4) | Table read index |
| rd_data | output | 64 | Table entry at `rd_idx` |

## Verification
The assertions check the per-cycle rules on every cycle: the attribute encoding of each offered descriptor, the bound on piece length, the address advancing by exactly the accepted length, stability under back-pressure, the single-cycle `done`, the end flag terminating the chain, and a quiet stream when idle. Only the bench scenarios can show the full chain compared against a computed expectation. This covers the exact split at 65,528 bytes, the error priority, the 16-entry limit on both sides of the boundary, table contents that survive a shorter follow-up chain, and a `start` that is ignored mid-chain.

// File: rtl/adt_pkg.sv
package adt_pkg;

  typedef enum logic [1:0] {
    ADT_OK       = 2'd0,
    ADT_MISALIGN = 2'd1,
    ADT_BADADDR  = 2'd2
  } adt_err_e;

  localparam int        ATTR_VALID_BIT = 0;
  localparam int        ATTR_END_BIT   = 1;
  localparam int        ATTR_IRQ_BIT   = 2;
  localparam logic [1:0] ATTR_ACT_XFER = 2'b10;

  // R1: address [63:32], length [31:16], attribute [15:0]
  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic [15:0] attr;
  } adt_desc_t;

  function automatic logic [15:0] adt_attr(input logic last);
    logic [15:0] a;
    a = '0;
    a[ATTR_VALID_BIT] = 1'b1;
    a[ATTR_END_BIT]   = last;
    a[ATTR_IRQ_BIT]   = 1'b0;
    a[5:4]            = ATTR_ACT_XFER;
    return a;
  endfunction

endpackage

// File: rtl/adt_screen.sv
module adt_screen
  import adt_pkg::*;
#(
  parameter int BASE_W    = 64,
  parameter int LEN_W     = 32,
  parameter int DEPTH     = 16,
  parameter int CHUNK_MAX = 65528
) (
  input  logic [BASE_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output adt_err_e          err
);

  localparam logic [63:0] LIMIT = 64'(DEPTH) * 64'(CHUNK_MAX);

  logic hi_set;
  logic len_zero;
  logic len_big;

  generate
    if (BASE_W > 32) begin : g_hi
      assign hi_set = |base[BASE_W-1:32];
    end else begin : g_nohi
      assign hi_set = 1'b0;
    end
  endgenerate

  assign len_zero = (len == '0);
  assign len_big  = (64'(len) > LIMIT);

  // Priority: zero length, then address range, then table capacity.
  always_comb begin
    if (len_zero)      err = ADT_MISALIGN;
    else if (hi_set)   err = ADT_BADADDR;
    else if (len_big)  err = ADT_MISALIGN;
    else               err = ADT_OK;
  end

endmodule

// File: rtl/adt_slicer.sv
module adt_slicer
  import adt_pkg::*;
#(
  parameter int LEN_W     = 32,
  parameter int CHUNK_MAX = 65528
) (
  input  logic [LEN_W-1:0] remain,
  input  logic [31:0]      addr,
  output logic [15:0]      piece,
  output logic             last,
  output adt_desc_t        desc
);

  localparam logic [LEN_W-1:0] CMAX = LEN_W'(CHUNK_MAX);

  always_comb begin
    last  = (remain <= CMAX);
    piece = last ? remain[15:0] : CMAX[15:0];
    desc.addr = addr;
    desc.len  = piece;
    desc.attr = adt_attr(last);
  end

endmodule

// File: rtl/adt_table.sv
module adt_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int DW    = 64
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  // Storage array: no reset, entries keep contents until rewritten.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/adt_gen.sv
module adt_gen
  import adt_pkg::*;
#(
  parameter int BASE_W    = 64,
  parameter int LEN_W     = 32,
  parameter int DEPTH     = 16,
  parameter int CHUNK_MAX = 65528,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BASE_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  total_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [CNT_W-1:0]  desc_count,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [63:0]       dsc_data,
  output logic [IDX_W-1:0]  dsc_index,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [63:0]       rd_data
);

  typedef enum logic { ST_IDLE = 1'b0, ST_GEN = 1'b1 } st_e;

  st_e              state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [31:0]      addr_q, addr_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  adt_err_e         err_q, err_d;
  logic             done_q, done_d;
  logic             walk_en;
  logic             stat_en;

  adt_err_e  screen_err;
  logic [15:0] piece;
  logic      last;
  adt_desc_t cur;
  logic      accept;

  adt_screen #(
    .BASE_W(BASE_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .CHUNK_MAX(CHUNK_MAX)
  ) u_screen (
    .base(base_addr), .len(total_len), .err(screen_err)
  );

  adt_slicer #(
    .LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)
  ) u_slicer (
    .remain(rem_q), .addr(addr_q), .piece(piece), .last(last), .desc(cur)
  );

  assign busy      = (state_q == ST_GEN);
  assign dsc_valid = busy;
  assign dsc_data  = cur;
  assign dsc_index = idx_q[IDX_W-1:0];
  assign accept    = dsc_valid && dsc_ready;

  adt_table #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .DW(64)
  ) u_table (
    .clk(clk), .we(accept), .waddr(idx_q[IDX_W-1:0]), .wdata(cur),
    .raddr(rd_idx), .rdata(rd_data)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    done_d  = 1'b0;
    walk_en = 1'b0;
    stat_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          stat_en = 1'b1;
          err_d   = screen_err;
          cnt_d   = '0;
          if (screen_err != ADT_OK) begin
            done_d = 1'b1;
          end else begin
            walk_en = 1'b1;
            state_d = ST_GEN;
            rem_d   = total_len;
            addr_d  = base_addr[31:0];
            idx_d   = '0;
          end
        end
      end
      ST_GEN: begin
        if (dsc_ready) begin
          walk_en = 1'b1;
          rem_d   = rem_q - LEN_W'(piece);
          addr_d  = addr_q + 32'(piece);
          idx_d   = idx_q + 1'b1;
          if (last) begin
            stat_en = 1'b1;
            state_d = ST_IDLE;
            done_d  = 1'b1;
            cnt_d   = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      err_q   <= ADT_OK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (walk_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
        idx_q  <= idx_d;
      end
      if (stat_en) begin
        cnt_q <= cnt_d;
        err_q <= err_d;
      end
    end
  end

  assign done       = done_q;
  assign err_code   = err_q;
  assign desc_count = cnt_q;

  // Assertions
  p_attr_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> (dsc_data[0] && !dsc_data[2] && dsc_data[5:4] == 2'b10))
    else $error("attribute encoding broken");

  p_piece_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> (dsc_data[31:16] != 16'd0 && 32'(dsc_data[31:16]) <= 32'(CHUNK_MAX)))
    else $error("piece length out of range");

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dsc_data[1]) |=>
      (dsc_valid && dsc_data[63:32] == $past(dsc_data[63:32] + 32'(dsc_data[31:16]))))
    else $error("piece address did not advance by length");

  p_end_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dsc_data[1]) |=> (!busy && done && err_code == 2'd0))
    else $error("end flag did not close chain");

  p_err_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 2'd0) |-> (desc_count == '0))
    else $error("error with nonzero count");

  p_badaddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && total_len != '0 && (64'(base_addr) >> 32) != 64'd0) |=>
      (done && err_code == 2'd2 && !busy))
    else $error("high address not rejected");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_data) && $stable(dsc_index)))
    else $error("descriptor changed under back-pressure");

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dsc_valid)
    else $error("valid while idle");

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

endmodule

// File: tb/sim_adt_gen.sv
`timescale 1ns/1ps
module sim_adt_gen;

  localparam int CM = 65528;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] base_addr;
  logic [31:0] total_len;
  logic        busy;
  logic        done;
  logic [1:0]  err_code;
  logic [4:0]  desc_count;
  logic        dsc_valid;
  logic        dsc_ready;
  logic [63:0] dsc_data;
  logic [3:0]  dsc_index;
  logic [3:0]  rd_idx;
  logic [63:0] rd_data;

  int nchk;
  int nerr;
  logic [63:0] got [0:31];
  int          ngot;
  logic [63:0] keep [0:15];

  adt_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .total_len(total_len), .busy(busy), .done(done), .err_code(err_code),
    .desc_count(desc_count), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_data(dsc_data), .dsc_index(dsc_index), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_err(input logic [63:0] b, input logic [31:0] l);
    if (l == 0) return 1;
    if (b[63:32] != 0) return 2;
    if ((l + CM - 1) / CM > 16) return 1;
    return 0;
  endfunction

  function automatic int exp_n(input logic [31:0] l);
    return int'((l + CM - 1) / CM);
  endfunction

  function automatic logic [63:0] exp_desc(input logic [63:0] b, input logic [31:0] l,
                                           input int i);
    logic [31:0] cov, rem, pc;
    logic        lst;
    cov = 32'(i) * CM;
    rem = l - cov;
    lst = (rem <= CM);
    pc  = lst ? rem : CM;
    return {b[31:0] + cov, pc[15:0], (lst ? 16'h0023 : 16'h0021)};
  endfunction

  // mode: 0 always ready, 1 alternate, 2 ready one cycle in three
  task automatic run_req(input logic [63:0] b, input logic [31:0] l, input int mode,
                         input bit poke, input string tag);
    int cyc;
    int e;
    int n;
    ngot = 0;
    @(negedge clk);
    base_addr = b;
    total_len = l;
    start     = 1'b1;
    cyc = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      base_addr = b;
      total_len = l;
      if (poke && cyc == 2) begin
        chk(busy === 1'b1, {tag, " R10 busy mid-chain"}, 64'(busy), 64'd1);
        start = 1'b1;
        base_addr = 64'h0000_0000_7000_0000;
        total_len = 32'd512;
      end
      case (mode)
        1: dsc_ready = (cyc % 2) == 1;
        2: dsc_ready = (cyc % 3) == 2;
        default: dsc_ready = 1'b1;
      endcase
      #1;
      if (dsc_valid && dsc_ready) begin
        chk(dsc_index == 4'(ngot), {tag, " R9 index order"}, 64'(dsc_index), 64'(ngot));
        got[ngot] = dsc_data;
        ngot++;
      end
      if (done) break;
      cyc++;
      if (cyc > 400) break;
    end
    start = 1'b0;
    dsc_ready = 1'b0;
    e = exp_err(b, l);
    chk(done === 1'b1, {tag, " R11 done seen"}, 64'(done), 64'd1);
    chk(err_code == 2'(e), {tag, " R5/R6/R7 err_code"}, 64'(err_code), 64'(e));
    if (e != 0) begin
      chk(ngot == 0, {tag, " R5 no descriptor"}, 64'(ngot), 64'd0);
      chk(desc_count == 0, {tag, " R5 count zero"}, 64'(desc_count), 64'd0);
      chk(cyc == 0, {tag, " R5 done next cycle"}, 64'(cyc), 64'd0);
    end else begin
      n = exp_n(l);
      chk(ngot == n, {tag, " R4 emitted count"}, 64'(ngot), 64'(n));
      chk(desc_count == 5'(n), {tag, " R4 desc_count"}, 64'(desc_count), 64'(n));
      for (int i = 0; i < ngot && i < 32; i++)
        chk(got[i] == exp_desc(b, l, i), {tag, " R1/R2/R3 descriptor"}, got[i],
            exp_desc(b, l, i));
      for (int i = 0; i < n && i < 16; i++) begin
        rd_idx = 4'(i);
        #1;
        chk(rd_data == exp_desc(b, l, i), {tag, " R9 table entry"}, rd_data,
            exp_desc(b, l, i));
      end
    end
    @(negedge clk);
    chk(done === 1'b0, {tag, " R11 done pulse"}, 64'(done), 64'd0);
    chk(err_code == 2'(e), {tag, " R11 err held"}, 64'(err_code), 64'(e));
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0 && dsc_valid === 1'b0, "R10 reset idle",
        {61'd0, busy, done, dsc_valid}, 64'd0);
    chk(desc_count == 0 && err_code == 0, "R11 reset status",
        64'(desc_count), 64'd0);
  endtask

  task automatic t_single();   run_req(64'h1000_0000, 32'd512, 0, 0, "single512"); endtask
  task automatic t_split();    run_req(64'h2000_0000, CM + 4096, 1, 0, "split"); endtask
  task automatic t_exact();    run_req(64'h0000_0100, CM, 2, 0, "exactmax"); endtask
  task automatic t_odd();      run_req(64'hFFFF_FF00, 32'd100, 1, 0, "oddwrap"); endtask
  task automatic t_zero();     run_req(64'h1000_0000, 32'd0, 0, 0, "zerolen R5"); endtask
  task automatic t_badaddr();  run_req(64'h1_0000_0000, 32'd512, 0, 0, "badaddr R6"); endtask
  task automatic t_prio();     run_req(64'h1_0000_0000, 32'd0, 0, 0, "prio R6"); endtask
  task automatic t_over();     run_req(64'h3000_0000, 16 * CM + 1, 0, 0, "overflow R7"); endtask
  task automatic t_busyign();  run_req(64'h4000_0000, 3 * CM - 10, 2, 1, "busyignore R10"); endtask

  task automatic t_full_keep();
    run_req(64'h5000_0000, 16 * CM, 1, 0, "full16 R7");
    for (int i = 0; i < 16; i++) keep[i] = exp_desc(64'h5000_0000, 16 * CM, i);
    run_req(64'h6000_0000, 32'd2048, 0, 0, "short after full");
    for (int i = 1; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(rd_data == keep[i], "R9 entries beyond count unchanged", rd_data, keep[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    nchk = 0;
    nerr = 0;
    rst_n = 1'b0;
    start = 1'b0;
    base_addr = '0;
    total_len = '0;
    dsc_ready = 1'b0;
    rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_exact();
    t_odd();
    t_zero();
    t_badaddr();
    t_prio();
    t_over();
    t_busyign();
    t_full_keep();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule